// File: doc/BRIEF.md
# Byte-Addressed I2C Port Expander

This block is an I2C slave that gives a host eight general-purpose pins through four byte-wide registers. A master addresses the block, then sends one command byte, which is held as a register pointer. Any further bytes in that write go to the selected register. A later read returns the selected register, and that read may be joined to the write by a repeated START. Each pin has a direction bit, where 0 makes the pin an output. Each pin also has a drive value and a polarity bit that inverts the pin level the host reads back.

The bus is open-drain. The block samples SCL and SDA through synchronisers and never drives SCL. To pull SDA low it raises an output enable. The pins appear as a sampled input vector, an output value vector and an output-enable vector. Three strap inputs set the low bits of the slave address.

Top module: `pin_expander_i2c`

## Requirements
- R1: The slave address is 7'b0100 followed by strap[2:0], with strap[2] the most significant. When the address byte matches, the block pulls SDA low in the ninth clock (ACK). When it does not match, the block leaves SDA released and ignores the bus until the next START.
- R2: Bit 0 of the address byte is the direction. 0 starts a write transaction, so with straps 000 the byte is 0x40. 1 starts a read, so with straps 000 the byte is 0x41.
- R3: The first byte after a write address is a command. Values 0 (input), 1 (output), 2 (polarity) and 3 (direction) are acknowledged and stored as the register pointer.
- R4: A command of 4 or more is answered with NACK. The pointer keeps its value, and the block ignores the bus until the next START or STOP.
- R5: Register 0 reads as the synchronised pin levels XOR the polarity register. A write to register 0 is acknowledged and changes no register.
- R6: Register 1 is read/write. Its bits appear on pin_o. Writing 0x01 drives pin 0 high and pins 1 to 7 low.
- R7: Register 3 is read/write. pin_oe[i] is high exactly when bit i of register 3 is 0.
- R8: After reset: output register 0xFF, polarity 0x00, direction 0xFF (all pins inputs), pointer 0, SDA released.
- R9: A read returns the register selected by the stored pointer. The pointer survives a repeated START and STOPs. Every byte of a read, while the master keeps acknowledging, returns that same register.
- R10: After the master NACKs a read byte, the block releases SDA. A STOP at any point, even inside a byte, returns the block to idle with SDA released and no register changed by the unfinished byte.
- R11: Each data byte of a write transaction after the command goes to the pointed register. The pointer does not advance, so the last byte written stays.
- R12: Polarity register bits (register 2) set to 1 invert the matching input bit on read. Bits set to 0 pass the pin level through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, well above the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| sda_pull | output | 1 | 1 pulls SDA low; 0 releases it |
| strap | input | 3 | Address strap bits A2..A0 |
| pin_i | input | 8 | Sensed level of each pin |
| pin_o | output | 8 | Drive value of each pin |
| pin_oe | output | 8 | Output enable of each pin |

## Verification
The main function is tried with a table of write-then-read pairs across all four commands. Pin levels and polarity masks change between rows, so a swapped register select, an inverted direction sense or a missing XOR each gives a different readback. Boundary patterns cover these cases:
- command values 4 and 0xFF;
- a data byte sent after a refused command;
- wrong and strap-shifted addresses;
- several data bytes in one write;
- a three-byte read that ends with a NACK;
- a STOP in the middle of a byte.

These patterns separate pointer persistence from auto-increment, and a clean abort from a partial write.

// File: rtl/pxe_pkg.sv
package pxe_pkg;
   localparam int BYTE_W = 8;
   localparam int N_REGS = 4;
   localparam int PTR_W  = $clog2(N_REGS);
   localparam int CNT_W  = 4;

   typedef enum logic [PTR_W-1:0] {
      SEL_IN  = 2'd0,
      SEL_OUT = 2'd1,
      SEL_POL = 2'd2,
      SEL_DIR = 2'd3
   } reg_sel_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_CMD,
      ST_WDATA,
      ST_ACK,
      ST_RDATA,
      ST_RACK
   } link_st_t;
endpackage

// File: rtl/pxe_sync.sv
module pxe_sync #(
   parameter int         WIDTH   = 1,
   parameter int         STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pxe_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= RST_VAL;
         else if (s == 0) chain[s] <= d;
         else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pxe_regs.sv
module pxe_regs
   import pxe_pkg::*;
#(
   parameter int N_PINS = 8,
   parameter logic [N_PINS-1:0] OUT_RST = '1,
   parameter logic [N_PINS-1:0] POL_RST = '0,
   parameter logic [N_PINS-1:0] DIR_RST = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  reg_sel_t          wr_sel,
   input  logic [BYTE_W-1:0] wr_data,
   input  reg_sel_t          rd_sel,
   output logic [BYTE_W-1:0] rd_data,
   input  logic [N_PINS-1:0] pins_s,
   output logic [N_PINS-1:0] pin_o,
   output logic [N_PINS-1:0] pin_oe
);
   logic [N_PINS-1:0] out_q, pol_q, dir_q;
   logic [N_PINS-1:0] in_view;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= OUT_RST;
         pol_q <= POL_RST;
         dir_q <= DIR_RST;
      end else if (wr_en) begin
         unique case (wr_sel)
            SEL_OUT: out_q <= wr_data[N_PINS-1:0];
            SEL_POL: pol_q <= wr_data[N_PINS-1:0];
            SEL_DIR: dir_q <= wr_data[N_PINS-1:0];
            default: ;
         endcase
      end
   end

   for (genvar p = 0; p < N_PINS; p++) begin : g_pin
      assign in_view[p] = pins_s[p] ^ pol_q[p];
      assign pin_oe[p]  = ~dir_q[p];
      assign pin_o[p]   = out_q[p];
   end

   always_comb begin
      rd_data = '0;
      unique case (rd_sel)
         SEL_IN:  rd_data[N_PINS-1:0] = in_view;
         SEL_OUT: rd_data[N_PINS-1:0] = out_q;
         SEL_POL: rd_data[N_PINS-1:0] = pol_q;
         SEL_DIR: rd_data[N_PINS-1:0] = dir_q;
         default: rd_data = '0;
      endcase
   end

   // R5: a write aimed at the input register leaves all storage alone
   a_r5_input_ro: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_IN) |=> ($stable(out_q) && $stable(pol_q) && $stable(dir_q)));
   // R6: an output write lands on the pins next cycle
   a_r6_out_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_OUT) |=> (pin_o == $past(wr_data[N_PINS-1:0])));
   // R7: a direction write sets the enables to its complement
   a_r7_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_DIR) |=> (pin_oe == ~$past(wr_data[N_PINS-1:0])));
endmodule

// File: rtl/pxe_link.sv
module pxe_link
   import pxe_pkg::*;
#(
   parameter logic [3:0] ADDR_HI = 4'b0100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_s,
   input  logic              sda_s,
   input  logic [2:0]        strap,
   output logic              sda_pull,
   output logic              wr_en,
   output logic [BYTE_W-1:0] wr_data,
   output reg_sel_t          ptr,
   input  logic [BYTE_W-1:0] rd_data
);
   link_st_t          st, after;
   logic              scl_d, sda_d;
   logic [CNT_W-1:0]  cnt;
   logic [BYTE_W-1:0] shreg, txbuf;
   logic              mack;

   wire scl_rise = scl_s & ~scl_d;
   wire scl_fall = ~scl_s & scl_d;
   wire start_c  = scl_s & scl_d & sda_d & ~sda_s;
   wire stop_c   = scl_s & scl_d & ~sda_d & sda_s;
   wire byte_end = scl_fall && (cnt == CNT_W'(BYTE_W));
   wire addr_hit = (shreg[BYTE_W-1:1] == {ADDR_HI, strap});
   wire cmd_ok   = (shreg < BYTE_W'(N_REGS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_s;
         sda_d <= sda_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         after    <= ST_IDLE;
         cnt      <= '0;
         shreg    <= '0;
         txbuf    <= '0;
         mack     <= 1'b0;
         sda_pull <= 1'b0;
         wr_en    <= 1'b0;
         wr_data  <= '0;
         ptr      <= SEL_IN;
      end else begin
         wr_en <= 1'b0;
         if (start_c) begin
            st       <= ST_ADDR;
            cnt      <= '0;
            sda_pull <= 1'b0;
         end else if (stop_c) begin
            st       <= ST_IDLE;
            sda_pull <= 1'b0;
         end else begin
            unique case (st)
               ST_ADDR, ST_CMD, ST_WDATA: begin
                  if (scl_rise && cnt < CNT_W'(BYTE_W)) begin
                     shreg <= {shreg[BYTE_W-2:0], sda_s};
                     cnt   <= cnt + 1'b1;
                  end else if (byte_end) begin
                     cnt <= '0;
                     if (st == ST_ADDR) begin
                        if (addr_hit) begin
                           sda_pull <= 1'b1;
                           st       <= ST_ACK;
                           after    <= shreg[0] ? ST_RDATA : ST_CMD;
                        end else begin
                           st <= ST_IDLE;
                        end
                     end else if (st == ST_CMD) begin
                        if (cmd_ok) begin
                           ptr      <= reg_sel_t'(shreg[PTR_W-1:0]);
                           sda_pull <= 1'b1;
                           st       <= ST_ACK;
                           after    <= ST_WDATA;
                        end else begin
                           st <= ST_IDLE;
                        end
                     end else begin
                        wr_en    <= 1'b1;
                        wr_data  <= shreg;
                        sda_pull <= 1'b1;
                        st       <= ST_ACK;
                        after    <= ST_WDATA;
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     if (after == ST_RDATA) begin
                        txbuf    <= rd_data;
                        sda_pull <= ~rd_data[BYTE_W-1];
                     end else begin
                        sda_pull <= 1'b0;
                     end
                     cnt <= '0;
                     st  <= after;
                  end
               end
               ST_RDATA: begin
                  if (scl_fall) begin
                     if (cnt == CNT_W'(BYTE_W-1)) begin
                        sda_pull <= 1'b0;
                        cnt      <= '0;
                        st       <= ST_RACK;
                     end else begin
                        txbuf    <= {txbuf[BYTE_W-2:0], 1'b0};
                        sda_pull <= ~txbuf[BYTE_W-2];
                        cnt      <= cnt + 1'b1;
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) mack <= ~sda_s;
                  else if (scl_fall) begin
                     if (mack) begin
                        txbuf    <= rd_data;
                        sda_pull <= ~rd_data[BYTE_W-1];
                        cnt      <= '0;
                        st       <= ST_RDATA;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   // R1: a foreign address never gets an ACK
   a_r1_foreign_release: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_ADDR && byte_end && !addr_hit && !start_c && !stop_c) |=> !sda_pull);
   // R4: a refused command leaves the pointer as it was
   a_r4_bad_cmd_ptr: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_CMD && byte_end && !cmd_ok && !start_c && !stop_c) |=> (ptr == $past(ptr)));
   // R10: STOP always leaves the bus released and idle
   a_r10_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
      stop_c |=> (!sda_pull && st == ST_IDLE));
   // R9: SDA belongs to the master during its acknowledge slot
   a_r9_rack_free: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RACK) |-> !sda_pull);
endmodule

// File: rtl/pin_expander_i2c.sv
module pin_expander_i2c
   import pxe_pkg::*;
#(
   parameter int         N_PINS      = 8,
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] ADDR_HI     = 4'b0100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_pull,
   input  logic [2:0]        strap,
   input  logic [N_PINS-1:0] pin_i,
   output logic [N_PINS-1:0] pin_o,
   output logic [N_PINS-1:0] pin_oe
);
   if (N_PINS < 1 || N_PINS > BYTE_W) begin : g_bad_pins
      $error("pin_expander_i2c: N_PINS must be 1..8");
   end

   logic              scl_s, sda_s;
   logic [N_PINS-1:0] pins_s;
   logic              wr_en;
   logic [BYTE_W-1:0] wr_data, rd_data;
   reg_sel_t          ptr;

   pxe_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
      .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s}));

   pxe_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pin_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_i), .q(pins_s));

   pxe_link #(.ADDR_HI(ADDR_HI)) u_link (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .strap(strap),
      .sda_pull(sda_pull), .wr_en(wr_en), .wr_data(wr_data), .ptr(ptr),
      .rd_data(rd_data));

   pxe_regs #(.N_PINS(N_PINS)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(ptr), .wr_data(wr_data),
      .rd_sel(ptr), .rd_data(rd_data), .pins_s(pins_s), .pin_o(pin_o),
      .pin_oe(pin_oe));
endmodule

// File: tb/pin_expander_i2c_bench.sv
module pin_expander_i2c_bench;
   localparam int Q = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl = 1'b1;
   logic       sda_m = 1'b1;
   logic [2:0] strap = 3'b000;
   logic [7:0] pin_i = 8'hA5;
   logic       sda_pull;
   logic [7:0] pin_o, pin_oe;
   logic       sda_line;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   assign sda_line = sda_m & ~sda_pull;

   always #2 clk = ~clk;

   pin_expander_i2c u_pin_expander_i2c (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
      .sda_pull(sda_pull), .strap(strap), .pin_i(pin_i), .pin_o(pin_o),
      .pin_oe(pin_oe));

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic hq(); repeat (Q) @(negedge clk); endtask

   task automatic bus_start();
      if (!scl) begin sda_m = 1'b1; hq(); scl = 1'b1; hq(); end
      sda_m = 1'b1; hq();
      sda_m = 1'b0; hq();
      scl = 1'b0; hq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; hq();
      scl = 1'b1; hq();
      sda_m = 1'b1; hq();
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         sda_m = b[i]; hq();
         scl = 1'b1; hq(); hq();
         scl = 1'b0; hq();
      end
   endtask

   task automatic wbyte(input logic [7:0] b, output logic ack_n);
      send_bits(b, 8);
      sda_m = 1'b1; hq();
      scl = 1'b1; hq();
      ack_n = sda_line; hq();
      scl = 1'b0; hq();
   endtask

   task automatic rbyte(input logic give_ack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         hq();
         scl = 1'b1; hq();
         b[i] = sda_line; hq();
         scl = 1'b0;
      end
      hq();
      sda_m = give_ack ? 1'b0 : 1'b1; hq();
      scl = 1'b1; hq(); hq();
      scl = 1'b0; hq();
      sda_m = 1'b1;
   endtask

   function automatic logic [7:0] dev(input logic rd);
      return {4'b0100, strap, rd};
   endfunction

   task automatic write_reg(input logic [7:0] cmd, input logic [7:0] val);
      logic a;
      bus_start(); wbyte(dev(1'b0), a); wbyte(cmd, a); wbyte(val, a); bus_stop();
   endtask

   task automatic read_reg(input logic [7:0] cmd, output logic [7:0] v);
      logic a;
      bus_start(); wbyte(dev(1'b0), a); wbyte(cmd, a);
      bus_start(); wbyte(dev(1'b1), a); rbyte(1'b0, v); bus_stop();
   endtask

   // cmd, write value, pin levels, expected readback, expected pin_o, expected pin_oe
   localparam logic [47:0] VEC [9] = '{
      {8'h01, 8'h01, 8'h00, 8'h01, 8'h01, 8'h00},
      {8'h03, 8'hF0, 8'h00, 8'hF0, 8'h01, 8'h0F},
      {8'h02, 8'h0F, 8'h33, 8'h0F, 8'h01, 8'h0F},
      {8'h00, 8'hAA, 8'h33, 8'h3C, 8'h01, 8'h0F},
      {8'h00, 8'h00, 8'hC5, 8'hCA, 8'h01, 8'h0F},
      {8'h01, 8'h5A, 8'hC5, 8'h5A, 8'h5A, 8'h0F},
      {8'h02, 8'h00, 8'hC5, 8'h00, 8'h5A, 8'h0F},
      {8'h00, 8'h12, 8'h96, 8'h96, 8'h5A, 8'h0F},
      {8'h03, 8'h00, 8'h96, 8'h00, 8'h5A, 8'hFF}
   };

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic       a;
      logic [7:0] v;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      hq();
      // R8 reset state at the ports
      chk("R8 pin_o", pin_o, 8'hFF);
      chk("R8 pin_oe", pin_oe, 8'h00);
      chk("R8 sda", {7'd0, sda_pull}, 8'h00);
      // R8 pointer 0: a bare read returns pins (R2 read address 0x41)
      bus_start(); wbyte(8'h41, a);
      chk("R2 read addr ack", {7'd0, a}, 8'h00);
      rbyte(1'b0, v); bus_stop();
      chk("R8 ptr0 input", v, 8'hA5);
      read_reg(8'h01, v); chk("R8 out", v, 8'hFF);
      read_reg(8'h02, v); chk("R8 pol", v, 8'h00);
      read_reg(8'h03, v); chk("R8 dir", v, 8'hFF);

      // table: R3 R5 R6 R7 R12
      foreach (VEC[k]) begin
         pin_i = VEC[k][31:24];
         write_reg(VEC[k][47:40], VEC[k][39:32]);
         read_reg(VEC[k][47:40], v);
         chk($sformatf("R3/R5/R12 row%0d readback", k), v, VEC[k][23:16]);
         chk($sformatf("R6 row%0d pin_o", k), pin_o, VEC[k][15:8]);
         chk($sformatf("R7 row%0d pin_oe", k), pin_oe, VEC[k][7:0]);
      end
      // now out=5A pol=00 dir=00 ptr=3

      // R4 refused commands
      bus_start(); wbyte(8'h40, a); wbyte(8'h04, a);
      chk("R4 cmd 04 nack", {7'd0, a}, 8'h01);
      bus_stop();
      bus_start(); wbyte(8'h40, a); wbyte(8'hFF, a);
      chk("R4 cmd FF nack", {7'd0, a}, 8'h01);
      wbyte(8'h33, a);
      chk("R4 data after refusal nack", {7'd0, a}, 8'h01);
      bus_stop();
      bus_start(); wbyte(8'h41, a); rbyte(1'b0, v); bus_stop();
      chk("R4 pointer kept", v, 8'h00);
      chk("R4 dir unchanged", pin_oe, 8'hFF);

      // R11 several data bytes, no auto-increment
      bus_start(); wbyte(8'h40, a); wbyte(8'h01, a);
      wbyte(8'h11, a); wbyte(8'h22, a); bus_stop();
      chk("R11 last byte kept", pin_o, 8'h22);
      read_reg(8'h02, v); chk("R11 pol untouched", v, 8'h00);

      // R9 multi-byte read after repeated START, R10 release after NACK
      bus_start(); wbyte(8'h40, a); wbyte(8'h01, a);
      bus_start(); wbyte(8'h41, a);
      rbyte(1'b1, v); chk("R9 byte1", v, 8'h22);
      rbyte(1'b1, v); chk("R9 byte2", v, 8'h22);
      rbyte(1'b0, v); chk("R9 byte3", v, 8'h22);
      hq();
      chk("R10 released after nack", {7'd0, sda_pull}, 8'h00);
      bus_stop();

      // R1 address matching with straps
      bus_start(); wbyte(8'h42, a);
      chk("R1 foreign addr nack", {7'd0, a}, 8'h01);
      bus_stop();
      strap = 3'b001;
      bus_start(); wbyte(8'h42, a);
      chk("R1 strapped addr ack", {7'd0, a}, 8'h00);
      bus_stop();
      bus_start(); wbyte(8'h40, a);
      chk("R1 old addr nack", {7'd0, a}, 8'h01);
      bus_stop();
      strap = 3'b000;

      // R10 STOP inside a byte
      bus_start(); wbyte(8'h40, a); wbyte(8'h02, a);
      send_bits(8'hFF, 3); bus_stop();
      chk("R10 idle after stop", {7'd0, sda_pull}, 8'h00);
      read_reg(8'h02, v); chk("R10 partial byte dropped", v, 8'h00);
      write_reg(8'h01, 8'h01);
      chk("R6 write 0x01", pin_o, 8'h01);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule